// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block builds the word returned on a flash read while an embedded program or erase runs inside the device. A host polls the array by ordinary reads and learns from two in-band status bits whether the internal operation has finished. No separate status register is used: the status rides on the normal read data path.

While the busy flag is high, one status bit carries a polarity flag. During a program it is the inverse of the matching bit of the word being written. During an erase it is forced low. A second status bit inverts on every read access, whether that access is signalled by the output-enable strobe or by the chip-enable strobe. When the busy flag drops, the status overrides disappear and the full array word is passed straight through. The toggle state then holds until the next operation.

The array, the command decoder and the write timer sit outside this block. They supply the busy flag, the kind of operation and the last loaded word.

Top module: `opstat_rdmux`

## Requirements
- R1: When `busy_i` is low, `rd_data_o` equals `arr_data_i` on all DATA_W bits, including directly after reset.
- R2: While `busy_i` is high and `op_kind_i` is 0 (program), bit POLL_BIT (default 7) of `rd_data_o` is the inverse of bit POLL_BIT of `load_data_i`.
- R3: While `busy_i` is high and `op_kind_i` is 1 (erase), bit POLL_BIT of `rd_data_o` is 0.
- R4: While `busy_i` is high, each clock cycle with `oe_rd_i` high inverts bit TOGGLE_BIT (default 6) of `rd_data_o` from the following cycle on.
- R5: A cycle with `ce_rd_i` high counts as a read access exactly like `oe_rd_i`. A cycle with both high counts as a single access, giving one inversion.
- R6: During an operation, with no read strobe, bit TOGGLE_BIT of `rd_data_o` stays stable.
- R7: Read strobes while `busy_i` is low do not advance the toggle. A following operation starts with the toggle value that the previous operation ended with.
- R8: While busy, the bits other than POLL_BIT and TOGGLE_BIT return `arr_data_i` when BUSY_ZERO_FILL is 0 (default) and return 0 when it is 1.
- R9: Status is valid in the very first cycle in which `busy_i` is high, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the toggle flop |
| busy_i | input | 1 | Embedded program or erase in progress |
| op_kind_i | input | 1 | 0 = program, 1 = erase |
| load_data_i | input | DATA_W | Last word loaded for programming |
| oe_rd_i | input | 1 | One-cycle pulse per read access gated by output enable |
| ce_rd_i | input | 1 | One-cycle pulse per read access gated by chip enable |
| arr_data_i | input | DATA_W | Data read from the array |
| rd_data_o | output | DATA_W | Word returned to the host |

## Verification
The bench tracks the toggle bit relative to its first observed value, because its starting state is not fixed. It checks that a single access with both strobes flips the bit exactly once. A design that treated the two strobes as two accesses would flip twice and show no change. Idle reads are issued between two operations to catch a toggle that keeps counting outside busy, which would make the next operation start on the wrong phase. Program and erase are checked against data with the polarity bit both set and clear, and in the first busy cycle. This exposes a swapped operation code, a missing inversion, or a status path that lags by a register.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } op_kind_e;
endpackage

// File: rtl/opstat_toggle.sv
module opstat_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic oe_rd_i,
   input  logic ce_rd_i,
   output logic tgl_o
);
   logic access;
   logic tgl_q;

   assign access = oe_rd_i | ce_rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tgl_q <= 1'b0;
      else if (busy_i && access)
         tgl_q <= ~tgl_q;
   end

   assign tgl_o = tgl_q;

   // R4 / R5: a busy read access inverts the flop exactly once
   assert_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && (oe_rd_i || ce_rd_i)) |=> (tgl_o != $past(tgl_o)));

   // R6 / R7: no busy access, no change
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_i && (oe_rd_i || ce_rd_i)) |=> $stable(tgl_o));
endmodule

// File: rtl/opstat_merge.sv
module opstat_merge #(
   parameter int DATA_W         = 16,
   parameter int POLL_BIT       = 7,
   parameter int TOGGLE_BIT     = 6,
   parameter bit BUSY_ZERO_FILL = 1'b0
) (
   input  logic              busy_i,
   input  logic              op_kind_i,
   input  logic              load_bit_i,
   input  logic              tgl_i,
   input  logic [DATA_W-1:0] arr_data_i,
   output logic [DATA_W-1:0] rd_data_o
);
   import opstat_pkg::*;

   localparam logic [DATA_W-1:0] STATUS_MASK =
      (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

   logic [DATA_W-1:0] busy_base;
   logic              poll_val;

   generate
      if (BUSY_ZERO_FILL) begin : g_zero_fill
         assign busy_base = '0;
      end else begin : g_pass_fill
         assign busy_base = arr_data_i & ~STATUS_MASK;
      end
   endgenerate

   always_comb begin
      poll_val = (op_kind_e'(op_kind_i) == OP_ERASE) ? 1'b0 : ~load_bit_i;
      if (busy_i) begin
         rd_data_o             = busy_base;
         rd_data_o[POLL_BIT]   = poll_val;
         rd_data_o[TOGGLE_BIT] = tgl_i;
      end else begin
         rd_data_o = arr_data_i;
      end
   end
endmodule

// File: rtl/opstat_rdmux.sv
module opstat_rdmux #(
   parameter int DATA_W         = 16,
   parameter int POLL_BIT       = 7,
   parameter int TOGGLE_BIT     = 6,
   parameter bit BUSY_ZERO_FILL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              op_kind_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              oe_rd_i,
   input  logic              ce_rd_i,
   input  logic [DATA_W-1:0] arr_data_i,
   output logic [DATA_W-1:0] rd_data_o
);
   initial begin
      if (DATA_W < 2)
         $error("DATA_W must be at least 2");
      if (POLL_BIT < 0 || POLL_BIT >= DATA_W)
         $error("POLL_BIT outside the data word");
      if (TOGGLE_BIT < 0 || TOGGLE_BIT >= DATA_W)
         $error("TOGGLE_BIT outside the data word");
      if (POLL_BIT == TOGGLE_BIT)
         $error("status bits must differ");
   end

   logic tgl;

   opstat_toggle u_toggle (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_i  (busy_i),
      .oe_rd_i (oe_rd_i),
      .ce_rd_i (ce_rd_i),
      .tgl_o   (tgl)
   );

   opstat_merge #(
      .DATA_W         (DATA_W),
      .POLL_BIT       (POLL_BIT),
      .TOGGLE_BIT     (TOGGLE_BIT),
      .BUSY_ZERO_FILL (BUSY_ZERO_FILL)
   ) u_merge (
      .busy_i     (busy_i),
      .op_kind_i  (op_kind_i),
      .load_bit_i (load_data_i[POLL_BIT]),
      .tgl_i      (tgl),
      .arr_data_i (arr_data_i),
      .rd_data_o  (rd_data_o)
   );

   // R1: idle passes array data untouched
   assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_i |-> (rd_data_o == arr_data_i));

   // R2: program polarity bit is inverted load data
   assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !op_kind_i) |-> (rd_data_o[POLL_BIT] != load_data_i[POLL_BIT]));

   // R3: erase polarity bit reads low
   assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && op_kind_i) |-> (rd_data_o[POLL_BIT] == 1'b0));

   // R4: output toggle bit inverts after a busy access that continues busy
   assert_out_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && (oe_rd_i || ce_rd_i)) ##1 busy_i |->
         (rd_data_o[TOGGLE_BIT] != $past(rd_data_o[TOGGLE_BIT])));
endmodule

// File: tb/opstat_rdmux_tb.sv
module opstat_rdmux_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          busy;
   logic          op_kind;
   logic [W-1:0]  load_data;
   logic          oe_rd;
   logic          ce_rd;
   logic [W-1:0]  arr_data;
   logic [W-1:0]  rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic tgl_ref;

   always #(CLK_PERIOD/2) clk = ~clk;

   opstat_rdmux u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (busy),
      .op_kind_i   (op_kind),
      .load_data_i (load_data),
      .oe_rd_i     (oe_rd),
      .ce_rd_i     (ce_rd),
      .arr_data_i  (arr_data),
      .rd_data_o   (rd_data)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_access(input logic use_oe, input logic use_ce);
      @(negedge clk);
      oe_rd = use_oe;
      ce_rd = use_ce;
      @(negedge clk);
      oe_rd = 1'b0;
      ce_rd = 1'b0;
      #1;
   endtask

   task automatic start_op(input logic kind, input logic [W-1:0] ld, input logic [W-1:0] arr);
      @(negedge clk);
      busy      = 1'b1;
      op_kind   = kind;
      load_data = ld;
      arr_data  = arr;
      #1;
   endtask

   task automatic end_op();
      @(negedge clk);
      busy = 1'b0;
      #1;
   endtask

   task automatic t_reset_idle();
      arr_data = 16'h5A3C;
      #1;
      check("R1 reset idle pass", rd_data, 16'h5A3C);
      arr_data = 16'hFFC0;
      #1;
      check("R1 idle pass ones", rd_data, 16'hFFC0);
   endtask

   task automatic t_program();
      start_op(1'b0, 16'h0080, 16'h1234);
      check("R9 first cycle program poll", {15'd0, rd_data[7]}, 16'd0);
      check("R8 other bits pass array", rd_data & 16'hFF3F, 16'h1234 & 16'hFF3F);
      tgl_ref = rd_data[6];
      read_access(1'b1, 1'b0);
      tgl_ref = ~tgl_ref;
      check("R4 oe read inverts", {15'd0, rd_data[6]}, {15'd0, tgl_ref});
      read_access(1'b1, 1'b0);
      tgl_ref = ~tgl_ref;
      check("R4 second oe read inverts", {15'd0, rd_data[6]}, {15'd0, tgl_ref});
      load_data = 16'h0000;
      #1;
      check("R2 program poll load bit low", {15'd0, rd_data[7]}, 16'd1);
      repeat (3) @(negedge clk);
      #1;
      check("R6 no read stable", {15'd0, rd_data[6]}, {15'd0, tgl_ref});
      read_access(1'b0, 1'b1);
      tgl_ref = ~tgl_ref;
      check("R5 ce read inverts", {15'd0, rd_data[6]}, {15'd0, tgl_ref});
      read_access(1'b1, 1'b1);
      tgl_ref = ~tgl_ref;
      check("R5 both strobes one inversion", {15'd0, rd_data[6]}, {15'd0, tgl_ref});
      end_op();
      check("R1 true data after program", rd_data, 16'h1234);
   endtask

   task automatic t_idle_then_erase();
      read_access(1'b1, 1'b0);
      read_access(1'b0, 1'b1);
      check("R7 idle reads pass data", rd_data, 16'h1234);
      start_op(1'b1, 16'h0000, 16'hFFFF);
      check("R3 erase poll low", {15'd0, rd_data[7]}, 16'd0);
      check("R7 toggle held across idle", {15'd0, rd_data[6]}, {15'd0, tgl_ref});
      check("R8 erase other bits pass", rd_data & 16'hFF3F, 16'hFF3F);
      read_access(1'b0, 1'b1);
      tgl_ref = ~tgl_ref;
      check("R4 erase read inverts", {15'd0, rd_data[6]}, {15'd0, tgl_ref});
      end_op();
      check("R1 true data after erase", rd_data, 16'hFFFF);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      busy = 1'b0;
      op_kind = 1'b0;
      load_data = '0;
      oe_rd = 1'b0;
      ce_rd = 1'b0;
      arr_data = '0;
      tgl_ref = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_idle();
      t_program();
      t_idle_then_erase();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule